// File: doc/BRIEF.md
# ADC Serial Frame Slave Interface

This block is the device side of a 16-clock serial frame for an eight-channel, 12-bit sampling converter. The host lowers chip select to begin a frame. At that moment the block latches the channel being sampled, takes a 12-bit result from a parallel stub port, pulses a conversion-start strobe and enables its data-out driver. It then shifts out one zero bit, a three-bit channel tag and the 12-bit result, launching one bit on each falling serial clock.

On the same falling edges it samples the serial input. At the chip-select rise that ends a complete frame, the received word goes either to a 12-bit control register or, in the frame after a write that asked for it, to a 16-bit shadow register. The shadow register holds two channel masks, and together they define a scan sequence. When sequencing is on, every chip-select fall moves the channel pointer to the next enabled slot. A track output tells an external hold stage when to return to tracking the input.

All pins are sampled through a synchronizer on the system clock. The serial clock must therefore run well below the system clock: each of its phases must last at least four system clocks.

Top module: `adc_frame_slave`

## Requirements
- R1: After reset, sdo_oe is 0, track is 1, sample_chan is 0, the control register is zero and the shadow register is zero.
- R2: A falling chip select enables the driver (sdo_oe 1) with sdo 0 as the leading zero, drops track to 0, pulses conv_start for one clock and captures conv_data together with the current channel.
- R3: The output word is, MSB first: a 0, the three-bit channel tag, then the 12-bit result. Falling serial edge k (k = 1..15) presents word bit 15-k on sdo.
- R4: On the 16th falling serial edge of a frame, sdo_oe returns to 0.
- R5: If chip select rises before the 16th falling edge, the frame is abandoned. sdo_oe goes to 0, track goes to 1, and neither register nor the channel pointer changes.
- R6: A complete frame whose first received bit is 1 loads the control register from the first 12 bits received, at the chip-select rise. The bit received first is control bit 11 (write). Bit 10 is sequence enable, bit 9 is unused, bits 8:6 are the channel and bit 5 is shadow mode. If the first bit is 0, nothing is written.
- R7: A control write with sequence enable 0 selects the written channel. sample_chan shows it, and the next frame's tag carries it.
- R8: After a control write with shadow mode 1, the next complete frame stores all 16 received bits (first received = bit 15) into the shadow register at its chip-select rise, and control is not changed by that frame.
- R9: track returns to 1 on the 14th falling serial edge. In a frame that writes the shadow register, it stays 0 until chip select rises.
- R10: A shadow commit points the channel at the first enabled slot. Slot s < 8 is channel s, enabled by shadow bit 8+s. Slot s >= 8 is channel s-8, enabled by shadow bit s-8. If no slot is enabled, the channel is 0.
- R11: With sequence enable 1, each falling chip select samples the current channel and then moves the pointer to the next enabled slot in ascending order, wrapping from slot 15 to slot 0. With no slot enabled, the pointer holds.
- R12: With sequence enable 0, a falling chip select leaves the channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data from host |
| conv_data | input | 12 | Conversion result from the stub |
| sdo | output | 1 | Serial data bit (valid while sdo_oe is 1) |
| sdo_oe | output | 1 | Output enable for the data-out driver |
| sdo_pin | output | 1 | Three-state data-out pin |
| track | output | 1 | 1 = hold stage tracks, 0 = hold |
| conv_start | output | 1 | One-clock pulse at frame start |
| sample_chan | output | 3 | Channel the next frame will sample |

## Verification
The bound checker looks at every clock at the events that separate pieces of logic raise. It checks that a chip-select fall opens the driver with a zero and holds the input, and that the 16th edge closes the driver. It also checks that an abandoned frame or a frame with the write flag clear leaves control untouched, that track comes back at the 14th edge except in shadow frames, and that the pointer does not move while sequencing is off. Only the bench's frame scenarios can show the order of the shifted bits, the field decoding of a control write, the two-frame shadow programming, and the ascending, wrapping walk across both masks.

// File: rtl/adc_fs_pkg.sv
package adc_fs_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DATA_W     = 12;
  localparam int CHAN_W     = 3;
  localparam int NUM_CHAN   = 1 << CHAN_W;
  localparam int SLOTS      = 2 * NUM_CHAN;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int CTRL_W     = 12;
  localparam int TRACK_EDGE = 14;

  typedef struct packed {
    logic              wr;
    logic              seq;
    logic              spare;
    logic [CHAN_W-1:0] chan;
    logic              shadow;
    logic [4:0]        rsvd;
  } ctrl_t;

  // slot s < NUM_CHAN uses the upper mask, the rest use the lower mask
  function automatic logic slot_on(input logic [SLOTS-1:0] mask,
                                   input logic [SLOT_W-1:0] s);
    logic [SLOT_W-1:0] idx;
    if (s < SLOT_W'(NUM_CHAN)) idx = s + SLOT_W'(NUM_CHAN);
    else                       idx = s - SLOT_W'(NUM_CHAN);
    return mask[idx];
  endfunction

  function automatic logic [SLOT_W-1:0] first_slot(input logic [SLOTS-1:0] mask);
    logic [SLOT_W-1:0] r;
    logic              hit;
    r   = '0;
    hit = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!hit && slot_on(mask, SLOT_W'(s))) begin
        r   = SLOT_W'(s);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOTS-1:0] mask,
                                                  input logic [SLOT_W-1:0] cur);
    logic [SLOT_W-1:0] r;
    logic [SLOT_W-1:0] cand;
    logic              hit;
    r   = cur;
    hit = 1'b0;
    for (int k = 1; k <= SLOTS; k++) begin
      cand = cur + SLOT_W'(k);
      if (!hit && slot_on(mask, cand)) begin
        r   = cand;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [FRAME_BITS-1:0] make_word(input logic [CHAN_W-1:0] ch,
                                                      input logic [DATA_W-1:0] d);
    return {1'b0, ch, d};
  endfunction
endpackage

// File: rtl/adc_fs_sync_edge.sv
module adc_fs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_fall_o,
  output logic sdi_o
);
  localparam int LANES = 3;
  localparam logic [LANES-1:0] IDLE = 3'b110; // {cs_n, sclk, sdi}

  logic [LANES-1:0] chain [STAGES];
  logic [LANES-1:0] prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= IDLE;
          else        chain[0] <= {cs_n_i, sclk_i, sdi_i};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= IDLE;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= chain[STAGES-1];
  end

  assign cs_fall_o   =  prev[2] & ~chain[STAGES-1][2];
  assign cs_rise_o   = ~prev[2] &  chain[STAGES-1][2];
  assign sclk_fall_o =  prev[1] & ~chain[STAGES-1][1];
  assign sdi_o       =  chain[STAGES-1][0];
endmodule

// File: rtl/adc_fs_frame.sv
module adc_fs_frame
  import adc_fs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_fall,
  input  logic                  cs_rise,
  input  logic                  sclk_fall,
  input  logic                  sdi_s,
  input  logic                  shadow_pend,
  input  logic [CHAN_W-1:0]     cur_chan,
  input  logic [DATA_W-1:0]     conv_data,
  output logic                  in_frame,
  output logic                  shadow_frame,
  output logic [CNT_W-1:0]      edge_cnt,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  commit,
  output logic                  abort,
  output logic                  sdo,
  output logic                  sdo_oe,
  output logic                  track,
  output logic                  conv_start
);
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] word_now;
  logic [CNT_W-1:0]      cnt_nxt;
  logic                  shift_en;

  assign word_now = make_word(cur_chan, conv_data);
  assign shift_en = in_frame && sclk_fall && (edge_cnt < CNT_W'(FRAME_BITS)) && !cs_rise;
  assign cnt_nxt  = edge_cnt + 1'b1;
  assign commit   = in_frame && cs_rise && (edge_cnt == CNT_W'(FRAME_BITS));
  assign abort    = in_frame && cs_rise && (edge_cnt != CNT_W'(FRAME_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame     <= 1'b0;
      shadow_frame <= 1'b0;
      edge_cnt     <= '0;
      rx_word      <= '0;
      tx_sh        <= '0;
      sdo          <= 1'b0;
      sdo_oe       <= 1'b0;
      track        <= 1'b1;
      conv_start   <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (cs_fall) begin
        in_frame     <= 1'b1;
        shadow_frame <= shadow_pend;
        edge_cnt     <= '0;
        rx_word      <= '0;
        sdo          <= word_now[FRAME_BITS-1];
        tx_sh        <= {word_now[FRAME_BITS-2:0], 1'b0};
        sdo_oe       <= 1'b1;
        track        <= 1'b0;
        conv_start   <= 1'b1;
      end else if (in_frame && cs_rise) begin
        in_frame     <= 1'b0;
        shadow_frame <= 1'b0;
        sdo_oe       <= 1'b0;
        sdo          <= 1'b0;
        track        <= 1'b1;
      end else if (shift_en) begin
        edge_cnt <= cnt_nxt;
        rx_word  <= {rx_word[FRAME_BITS-2:0], sdi_s};
        if (cnt_nxt == CNT_W'(FRAME_BITS)) begin
          sdo_oe <= 1'b0;
          sdo    <= 1'b0;
        end else begin
          sdo   <= tx_sh[FRAME_BITS-1];
          tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
        end
        if (cnt_nxt == CNT_W'(TRACK_EDGE) && !shadow_frame) track <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_fs_regs.sv
module adc_fs_regs
  import adc_fs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_fall,
  input  logic                  commit,
  input  logic                  shadow_frame,
  input  logic [FRAME_BITS-1:0] rx_word,
  output ctrl_t                 ctrl_q,
  output logic [SLOTS-1:0]      shadow_q,
  output logic                  shadow_pend,
  output logic [SLOT_W-1:0]     slot_q,
  output logic                  seq_on
);
  ctrl_t rx_ctrl;

  assign rx_ctrl = ctrl_t'(rx_word[FRAME_BITS-1 -: CTRL_W]);
  assign seq_on  = ctrl_q.seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      shadow_q    <= '0;
      shadow_pend <= 1'b0;
      slot_q      <= '0;
    end else if (commit) begin
      if (shadow_frame) begin
        shadow_q    <= rx_word;
        shadow_pend <= 1'b0;
        slot_q      <= first_slot(rx_word);
      end else if (rx_ctrl.wr) begin
        ctrl_q      <= rx_ctrl;
        shadow_pend <= rx_ctrl.shadow;
        if (!rx_ctrl.seq) slot_q <= {1'b0, rx_ctrl.chan};
      end
    end else if (cs_fall && ctrl_q.seq) begin
      slot_q <= next_slot(shadow_q, slot_q);
    end
  end
endmodule

// File: rtl/adc_frame_slave.sv
module adc_frame_slave
  import adc_fs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] conv_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sdo_pin,
  output logic              track,
  output logic              conv_start,
  output logic [CHAN_W-1:0] sample_chan
);
  logic                  cs_fall, cs_rise, sclk_fall, sdi_s;
  logic                  in_frame, shadow_frame, commit, abort;
  logic [CNT_W-1:0]      edge_cnt;
  logic [FRAME_BITS-1:0] rx_word;
  ctrl_t                 ctrl_q;
  logic [SLOTS-1:0]      shadow_q;
  logic                  shadow_pend, seq_on;
  logic [SLOT_W-1:0]     slot_q;

  adc_fs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise), .sclk_fall_o(sclk_fall), .sdi_o(sdi_s)
  );

  adc_fs_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s), .shadow_pend(shadow_pend),
    .cur_chan(sample_chan), .conv_data(conv_data), .in_frame(in_frame),
    .shadow_frame(shadow_frame), .edge_cnt(edge_cnt), .rx_word(rx_word),
    .commit(commit), .abort(abort), .sdo(sdo), .sdo_oe(sdo_oe),
    .track(track), .conv_start(conv_start)
  );

  adc_fs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .commit(commit),
    .shadow_frame(shadow_frame), .rx_word(rx_word), .ctrl_q(ctrl_q),
    .shadow_q(shadow_q), .shadow_pend(shadow_pend), .slot_q(slot_q),
    .seq_on(seq_on)
  );

  assign sample_chan = slot_q[CHAN_W-1:0];
  assign sdo_pin     = sdo_oe ? sdo : 1'bz;
endmodule

// File: rtl/adc_fs_chk.sv
module adc_fs_chk
  import adc_fs_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_fall,
  input logic                  sclk_fall,
  input logic                  in_frame,
  input logic                  shadow_frame,
  input logic [CNT_W-1:0]      edge_cnt,
  input logic                  commit,
  input logic                  abort,
  input logic [FRAME_BITS-1:0] rx_word,
  input logic [CTRL_W-1:0]     ctrl_bits,
  input logic [SLOT_W-1:0]     slot_q,
  input logic                  seq_on,
  input logic                  sdo,
  input logic                  sdo_oe,
  input logic                  track,
  input logic                  conv_start
);
  // R2
  cs_fall_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_oe && !sdo && !track && conv_start));
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R4
  last_edge_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && sclk_fall && !commit && !abort && !cs_fall &&
     edge_cnt == CNT_W'(FRAME_BITS-1)) |=> !sdo_oe);
  // R5
  abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ($stable(ctrl_bits) && $stable(slot_q) && !sdo_oe && track));
  // R6
  no_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !shadow_frame && !rx_word[FRAME_BITS-1]) |=> $stable(ctrl_bits));
  // R9
  track_edge14_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && sclk_fall && !shadow_frame && !commit && !abort && !cs_fall &&
     edge_cnt == CNT_W'(TRACK_EDGE-1)) |=> track);
  // R9
  shadow_track_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && shadow_frame) |-> !track);
  // R12
  seq_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !seq_on) |=> $stable(slot_q));
  // R4
  oe_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> in_frame);
endmodule

bind adc_frame_slave adc_fs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
  .in_frame(in_frame), .shadow_frame(shadow_frame), .edge_cnt(edge_cnt),
  .commit(commit), .abort(abort), .rx_word(rx_word), .ctrl_bits(ctrl_q),
  .slot_q(slot_q), .seq_on(seq_on), .sdo(sdo), .sdo_oe(sdo_oe),
  .track(track), .conv_start(conv_start)
);

// File: tb/adc_frame_slave_tb.sv
module adc_frame_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdi = 1'b0;
  logic [11:0] conv_data = '0;
  logic        sdo, sdo_oe, sdo_pin, track, conv_start;
  logic [2:0]  sample_chan;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_chan = 0;
  bit m_seq = 0;
  bit m_pend = 0;
  int m_list[$];
  int m_idx = 0;

  always #4 clk = ~clk;

  adc_frame_slave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .conv_data(conv_data), .sdo(sdo), .sdo_oe(sdo_oe), .sdo_pin(sdo_pin),
    .track(track), .conv_start(conv_start), .sample_chan(sample_chan)
  );

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] din, input int nclk, input logic [11:0] data,
                           input string req);
    logic [15:0] word;
    int tag;
    bit shf;
    shf = m_pend;
    if (m_seq && m_list.size() > 0) begin
      tag    = m_list[m_idx];
      m_idx  = (m_idx + 1) % m_list.size();
      m_chan = m_list[m_idx];
    end else begin
      tag = m_chan;
    end
    word = {1'b0, 3'(tag), data};
    conv_data = data;
    cs_n = 1'b0;
    ticks(8);
    check({req, " R2 oe"}, sdo_oe, 1);
    check({req, " R2 lead"}, sdo, 0);
    check({req, " R2 track"}, track, 0);
    for (int k = 1; k <= nclk; k++) begin
      sdi = din[16-k];
      ticks(8);
      sclk = 1'b0;
      ticks(8);
      if (k < 16) begin
        check({req, " R3 bit"}, sdo, int'(word[15-k]));
        check({req, " R3 oe"}, sdo_oe, 1);
      end else begin
        check({req, " R4 hiz"}, sdo_oe, 0);
      end
      check({req, " R9 track"}, track, (k >= 14 && !shf) ? 1 : 0);
      sclk = 1'b1;
    end
    ticks(8);
    cs_n = 1'b1;
    ticks(8);
    check({req, " R5 oe end"}, sdo_oe, 0);
    check({req, " R9 track end"}, track, 1);
    if (nclk == 16) begin
      if (shf) begin
        m_list.delete();
        for (int s = 0; s < 16; s++)
          if ((s < 8) ? din[8+s] : din[s-8]) m_list.push_back(s % 8);
        m_pend = 0;
        m_idx  = 0;
        m_chan = (m_list.size() > 0) ? m_list[0] : 0;
      end else if (din[15]) begin
        m_seq  = din[14];
        m_pend = din[9];
        if (!din[14]) m_chan = int'(din[12:10]);
      end
    end
    check({req, " chan"}, sample_chan, m_chan);
    ticks(4);
  endtask

  initial begin
    ticks(5);
    // R1
    check("R1 oe", sdo_oe, 0);
    check("R1 track", track, 1);
    check("R1 chan", sample_chan, 0);
    check("R1 pin", (sdo_pin === 1'bz) ? 1 : 0, 1);
    rst_n = 1'b1;
    ticks(5);
    run_frame(16'h0000, 16, 12'hA5C, "R3 read ch0");
    // R6 R7: write, seq off, channel 5
    run_frame(16'h9400, 16, 12'h123, "R6 R7 write ch5");
    run_frame(16'h0000, 16, 12'hFFF, "R7 tag5");
    // R6: first bit 0, ignored
    run_frame(16'h0C00, 16, 12'h0F0, "R6 no write");
    run_frame(16'h0000, 16, 12'h00F, "R6 still5");
    // R5: aborted write to channel 2
    run_frame(16'h8800, 10, 12'h555, "R5 abort");
    run_frame(16'h0000, 16, 12'hAAA, "R5 still5");
    // R8: shadow mode with sequence on
    run_frame(16'hC200, 16, 12'h321, "R8 ctrl");
    run_frame(16'h1204, 16, 12'h456, "R8 R9 shadow");
    // R10 R11: walk 1,4,2 and wrap
    for (int i = 0; i < 5; i++) run_frame(16'h0000, 16, 12'(i * 291), "R10 R11 seq");
    // R12: sequence off, channel 7
    run_frame(16'h9C00, 16, 12'h777, "R12 write ch7");
    run_frame(16'h0000, 16, 12'h0AB, "R12 hold");
    run_frame(16'h0000, 16, 12'hBA0, "R12 hold2");
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule